// File: doc/BRIEF.md
# Conversion Clock Source Selector

This block picks the clock that paces an analog-to-digital converter's conversions. The clock comes either from an on-chip oscillator or from an external clock pin. The block keeps watching the external pin. When a signal toggles at least at the minimum qualifying rate, it turns the on-chip oscillator off and gates the external clock through. When that signal stops, it restarts the oscillator and returns to it. A source change never takes effect in the middle of a conversion. A requested change waits until the converter reports that it is asleep or shifting data out.

All logic runs on the reference clock `clk_ref`. The external pin goes through a two-stage synchroniser. An edge detector then finds its rising and falling edges. A presence detector splits time into fixed windows of `WIN_CYC = REF_HZ / MIN_EXT_HZ` reference cycles, which is 100 by default and corresponds to a 100 µs window for a 10 kHz minimum rate. The detector only changes its verdict when two consecutive windows agree.

A four-state machine drives the two clock gates, `int_gate_en` and `ext_gate_en`, with a break-before-make sequence:

- **ST_INT**: the internal oscillator runs and its gate is open. It moves to ST_TO_EXT on *present and idle*.
- **ST_TO_EXT**: both gates are closed and the oscillator still runs. It moves to ST_EXT on a *synchronised external falling edge while still present and idle*. It returns to ST_INT on *abort*, meaning presence is lost or the idle indication drops.
- **ST_EXT**: the external gate is open and the oscillator is off. It moves to ST_TO_INT on *absent and idle*.
- **ST_TO_INT**: both gates are closed and the oscillator is restarting. It moves to ST_INT after *wake done*, which takes `OSC_WAKE` cycles.

Top module: `convclk_src_sel`

## Requirements
- R1: After reset, `int_osc_en`=1, `int_gate_en`=1, `ext_gate_en`=0 and `ext_detected`=0.
- R2: `ext_detected` rises only after two consecutive windows of `WIN_CYC` cycles each contain at least one synchronised rising edge of `ext_clk_pin`. It falls only after two consecutive windows contain none. It changes only at a window end, and never less than 80 cycles after the external clock starts.
- R3: An external clock whose period spans three windows (300 cycles by default) is never reported present.
- R4: A single isolated pulse does not set `ext_detected`. A pause shorter than two windows in a running external clock does not clear it.
- R5: Detection depends only on rising edges, so a 15 % duty cycle (3 cycles high, 17 low) is detected like any other duty cycle.
- R6: With `ext_detected`=1 and `conv_idle`=1, the internal gate closes first. The external gate then opens one cycle after a synchronised falling edge of the pin, and `int_osc_en` goes low only while the external gate is open.
- R7: `int_gate_en` and `ext_gate_en` are never both 1. A gate never opens in the cycle right after the other gate was open.
- R8: While `conv_idle`=0, neither gate changes in response to a change in detection. The pending change is applied once `conv_idle` returns to 1.
- R9: With the external gate open, once `ext_detected`=0 and `conv_idle`=1, the external gate closes and `int_osc_en` goes high. The internal gate opens `OSC_WAKE` cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock for all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk_pin | input | 1 | External clock pin, asynchronous |
| conv_idle | input | 1 | 1 while the converter sleeps or outputs data |
| int_osc_en | output | 1 | Enable for the on-chip oscillator |
| int_gate_en | output | 1 | Gate enable for the internal clock path |
| ext_gate_en | output | 1 | Gate enable for the external clock path; 1 means external selected |
| ext_detected | output | 1 | Status: a qualifying external clock is present |

## Verification
Detection results follow a stimulus only at window ends. After the external clock starts or stops, the verdict can take up to three windows plus three cycles of synchroniser and edge delay, so the bench waits 400 cycles before checking. It samples earlier (80 cycles) only to confirm that no change has happened yet. A gate change follows `conv_idle` by one cycle. Opening the external gate also waits for the next synchronised falling edge, at most one external period plus three cycles. A return to internal takes `OSC_WAKE`+1 cycles. Each scoreboard check is therefore queued well after these bounds, and the checks are sampled on the falling clock edge. Gate overlap and make-before-break ordering are checked on every cycle.

// File: rtl/convclk_pkg.sv
package convclk_pkg;
    typedef enum logic [1:0] {
        ST_INT    = 2'd0,
        ST_TO_EXT = 2'd1,
        ST_EXT    = 2'd2,
        ST_TO_INT = 2'd3
    } src_state_t;
endpackage

// File: rtl/convclk_sync.sv
module convclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/convclk_presence.sv
module convclk_presence #(
    parameter int WIN_CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s,
    output logic pin_fall,
    output logic win_end,
    output logic present
);
    localparam int CW = $clog2(WIN_CYC);

    logic          pin_d;
    logic          pin_rise;
    logic [CW-1:0] win_cnt;
    logic          seen;
    logic          win_hit;
    logic          last_hit;

    assign pin_rise = pin_s & ~pin_d;
    assign pin_fall = ~pin_s & pin_d;
    assign win_end  = (win_cnt == CW'(WIN_CYC - 1));
    assign win_hit  = seen | pin_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_d    <= 1'b0;
            win_cnt  <= '0;
            seen     <= 1'b0;
            last_hit <= 1'b0;
            present  <= 1'b0;
        end else begin
            pin_d <= pin_s;
            if (win_end) begin
                win_cnt  <= '0;
                seen     <= 1'b0;
                last_hit <= win_hit;
                if (win_hit == last_hit) present <= win_hit;
            end else begin
                win_cnt <= win_cnt + 1'b1;
                if (pin_rise) seen <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/convclk_switch_fsm.sv
module convclk_switch_fsm
    import convclk_pkg::*;
#(
    parameter int OSC_WAKE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic present,
    input  logic conv_idle,
    input  logic ext_fall,
    output logic int_osc_en,
    output logic int_gate_en,
    output logic ext_gate_en
);
    localparam int WW = $clog2(OSC_WAKE + 1);

    src_state_t    state, state_nx;
    logic [WW-1:0] wake_cnt;
    logic          wake_done;

    assign wake_done = (wake_cnt == WW'(OSC_WAKE - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_INT;
            wake_cnt <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_TO_INT) wake_cnt <= wake_cnt + 1'b1;
            else                    wake_cnt <= '0;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_INT:    if (present && conv_idle) state_nx = ST_TO_EXT;
            ST_TO_EXT: begin
                if (!present || !conv_idle) state_nx = ST_INT;
                else if (ext_fall)          state_nx = ST_EXT;
            end
            ST_EXT:    if (!present && conv_idle) state_nx = ST_TO_INT;
            ST_TO_INT: if (wake_done) state_nx = ST_INT;
        endcase
    end

    always_comb begin
        int_osc_en  = 1'b1;
        int_gate_en = 1'b0;
        ext_gate_en = 1'b0;
        unique case (state)
            ST_INT:    int_gate_en = 1'b1;
            ST_TO_EXT: ;
            ST_EXT: begin
                ext_gate_en = 1'b1;
                int_osc_en  = 1'b0;
            end
            ST_TO_INT: ;
        endcase
    end
endmodule

// File: rtl/convclk_src_sel.sv
module convclk_src_sel #(
    parameter int REF_HZ     = 1_000_000,
    parameter int MIN_EXT_HZ = 10_000,
    parameter int SYNC_STG   = 2,
    parameter int OSC_WAKE   = 4
) (
    input  logic clk_ref,
    input  logic rst_n,
    input  logic ext_clk_pin,
    input  logic conv_idle,
    output logic int_osc_en,
    output logic int_gate_en,
    output logic ext_gate_en,
    output logic ext_detected
);
    localparam int WIN_CYC = REF_HZ / MIN_EXT_HZ;

    logic pin_s;
    logic ext_fall;
    logic win_end;

    convclk_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .d     (ext_clk_pin),
        .q     (pin_s)
    );

    convclk_presence #(.WIN_CYC(WIN_CYC)) u_presence (
        .clk      (clk_ref),
        .rst_n    (rst_n),
        .pin_s    (pin_s),
        .pin_fall (ext_fall),
        .win_end  (win_end),
        .present  (ext_detected)
    );

    convclk_switch_fsm #(.OSC_WAKE(OSC_WAKE)) u_fsm (
        .clk         (clk_ref),
        .rst_n       (rst_n),
        .present     (ext_detected),
        .conv_idle   (conv_idle),
        .ext_fall    (ext_fall),
        .int_osc_en  (int_osc_en),
        .int_gate_en (int_gate_en),
        .ext_gate_en (ext_gate_en)
    );
endmodule

// File: rtl/convclk_src_sel_chk.sv
module convclk_src_sel_chk (
    input logic clk_ref,
    input logic rst_n,
    input logic conv_idle,
    input logic int_osc_en,
    input logic int_gate_en,
    input logic ext_gate_en,
    input logic ext_detected,
    input logic ext_fall,
    input logic win_end
);
    p_verdict_at_window_r2: assert property (@(posedge clk_ref) disable iff (!rst_n)
        ($rose(ext_detected) || $fell(ext_detected)) |-> $past(win_end));

    p_ext_on_fall_r6: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(ext_gate_en) |-> $past(ext_fall) && $past(ext_detected));

    p_osc_off_only_ext_r6: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !int_osc_en |-> ext_gate_en);

    p_no_overlap_r7: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !(int_gate_en && ext_gate_en));

    p_ext_break_first_r7: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(ext_gate_en) |-> !$past(int_gate_en));

    p_int_break_first_r7: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(int_gate_en) |-> !$past(ext_gate_en));

    p_switch_when_idle_r8: assert property (@(posedge clk_ref) disable iff (!rst_n)
        ($rose(ext_gate_en) || $fell(ext_gate_en)) |-> $past(conv_idle));

    p_leave_ext_absent_r9: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $fell(ext_gate_en) |-> !$past(ext_detected) && int_osc_en);
endmodule

bind convclk_src_sel convclk_src_sel_chk u_chk (
    .clk_ref      (clk_ref),
    .rst_n        (rst_n),
    .conv_idle    (conv_idle),
    .int_osc_en   (int_osc_en),
    .int_gate_en  (int_gate_en),
    .ext_gate_en  (ext_gate_en),
    .ext_detected (ext_detected),
    .ext_fall     (ext_fall),
    .win_end      (win_end)
);

// File: tb/convclk_src_sel_tb.sv
module convclk_src_sel_tb;
    logic clk_ref = 1'b0;
    logic rst_n = 1'b0;
    logic ext_clk_pin = 1'b0;
    logic conv_idle = 1'b1;
    logic int_osc_en, int_gate_en, ext_gate_en, ext_detected;

    always #5 clk_ref = ~clk_ref;

    convclk_src_sel u_dut (
        .clk_ref      (clk_ref),
        .rst_n        (rst_n),
        .ext_clk_pin  (ext_clk_pin),
        .conv_idle    (conv_idle),
        .int_osc_en   (int_osc_en),
        .int_gate_en  (int_gate_en),
        .ext_gate_en  (ext_gate_en),
        .ext_detected (ext_detected)
    );

    typedef struct {
        string tag;
        logic  det;
        logic  ig;
        logic  eg;
        logic  osc;
    } exp_t;

    exp_t q[$];
    event chk_ev;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   finished = 0;

    // external clock generator
    bit ext_run = 0;
    int ext_hi = 3;
    int ext_lo = 17;
    int ph = 0;
    always @(negedge clk_ref) begin
        if (!ext_run) begin
            ext_clk_pin <= 1'b0;
            ph <= 0;
        end else begin
            ext_clk_pin <= (ph < ext_hi);
            ph <= (ph + 1 >= ext_hi + ext_lo) ? 0 : ph + 1;
        end
    end

    // per-cycle gate ordering watch (R7)
    int   overlap = 0;
    int   bbm_bad = 0;
    logic ig_p = 1'b1, eg_p = 1'b0;
    always @(negedge clk_ref) begin
        if (rst_n) begin
            if (int_gate_en && ext_gate_en) overlap++;
            if (ext_gate_en && !eg_p && ig_p) bbm_bad++;
            if (int_gate_en && !ig_p && eg_p) bbm_bad++;
        end
        ig_p <= int_gate_en;
        eg_p <= ext_gate_en;
    end

    // monitor: pops expected items and compares
    initial begin
        forever begin
            @(chk_ev);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_chk++;
                if ({ext_detected, int_gate_en, ext_gate_en, int_osc_en} !==
                    {e.det, e.ig, e.eg, e.osc}) begin
                    n_bad++;
                    $display("FAIL %s: got det=%b ig=%b eg=%b osc=%b, expected det=%b ig=%b eg=%b osc=%b",
                             e.tag, ext_detected, int_gate_en, ext_gate_en, int_osc_en,
                             e.det, e.ig, e.eg, e.osc);
                end
            end
        end
    end

    task automatic expect_now(string tag, logic det, logic ig, logic eg, logic osc);
        exp_t e;
        e.tag = tag; e.det = det; e.ig = ig; e.eg = eg; e.osc = osc;
        q.push_back(e);
        -> chk_ev;
        #1;
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk_ref);
    endtask

    task automatic count_check(string tag, int got, int want);
        n_chk++;
        if (got != want) begin
            n_bad++;
            $display("FAIL %s: got %0d, expected %0d", tag, got, want);
        end
    endtask

    initial begin
        cyc(3);
        expect_now("R1 reset state", 1'b0, 1'b1, 1'b0, 1'b1);
        rst_n = 1'b1;
        cyc(2);
        expect_now("R1 after release", 1'b0, 1'b1, 1'b0, 1'b1);

        // R8/R5/R2: detection while busy, low duty cycle
        conv_idle = 1'b0;
        ext_hi = 3; ext_lo = 17; ext_run = 1;
        cyc(400);
        expect_now("R5 R2 detected, R8 deferred", 1'b1, 1'b1, 1'b0, 1'b1);
        cyc(50);
        expect_now("R8 still deferred", 1'b1, 1'b1, 1'b0, 1'b1);

        // R6: apply on idle
        conv_idle = 1'b1;
        cyc(30);
        expect_now("R6 switched to external", 1'b1, 1'b0, 1'b1, 1'b0);

        // R4: short pause keeps detection
        ext_run = 0;
        cyc(150);
        ext_run = 1;
        cyc(5);
        expect_now("R4 pause tolerated", 1'b1, 1'b0, 1'b1, 1'b0);
        cyc(300);
        expect_now("R4 still present", 1'b1, 1'b0, 1'b1, 1'b0);

        // R8: loss while busy keeps external gate
        conv_idle = 1'b0;
        ext_run = 0;
        cyc(400);
        expect_now("R8 loss deferred", 1'b0, 1'b0, 1'b1, 1'b0);

        // R9: fall back on idle
        conv_idle = 1'b1;
        cyc(2);
        expect_now("R9 gates closed, osc waking", 1'b0, 1'b0, 1'b0, 1'b1);
        cyc(8);
        expect_now("R9 back on internal", 1'b0, 1'b1, 1'b0, 1'b1);

        // R4: single pulse
        ext_hi = 3; ext_lo = 1000; ext_run = 1;
        cyc(10);
        ext_run = 0;
        cyc(400);
        expect_now("R4 single pulse ignored", 1'b0, 1'b1, 1'b0, 1'b1);

        // R3: too slow
        ext_hi = 150; ext_lo = 150; ext_run = 1;
        for (int i = 0; i < 5; i++) begin
            cyc(300);
            expect_now("R3 slow clock not detected", 1'b0, 1'b1, 1'b0, 1'b1);
        end
        ext_run = 0;
        cyc(400);

        // R2 timing bound, then R6 again with a fast clock
        ext_hi = 5; ext_lo = 5; ext_run = 1;
        cyc(80);
        expect_now("R2 not before two windows", 1'b0, 1'b1, 1'b0, 1'b1);
        cyc(320);
        expect_now("R2 R6 fast clock selected", 1'b1, 1'b0, 1'b1, 1'b0);

        count_check("R7 gate overlap cycles", overlap, 0);
        count_check("R7 make-before-break events", bbm_bad, 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk_ref);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule